// File: doc/BRIEF.md
# Detector Range Controller

This block keeps a sub-ranged amplitude detector within its linear region by choosing its bias mode from the detector's digitized output. Each strobed 8-bit sample is sorted into one of three bands. A sample in the low band means the detector output has sagged too far, so the block moves to the next higher mode. A sample in the high band means it has risen too far, so the block moves one mode down. A sample that lands inside the window is turned into an amplitude estimate.

The 3-bit mode drives the bias network through a 7-line thermometer code. The detector output falls as the input amplitude grows. The estimate therefore takes a base value, adds a slope term that grows as the code drops below mid-scale, and adds an offset for the current mode. That offset is 60 mV for the first step and 50 mV for each step after it. A programmable count of samples is thrown away after every mode change so that the analog bias can settle. At the two ends of the mode range, an out-of-window sample raises a flag and the mode does not move.

Top module: `det_autorange`

## Requirements
- R1: While reset is high and in the cycle after it falls, `mode` is 0, `therm` is all zero, and `amp_valid` and `out_of_range` are low.
- R2: Bit i of `therm` (i = 0..6) is 1 exactly when `mode` is greater than i, so mode m sets the m lowest bits.
- R3: An accepted sample with code below 43 and `mode` below 7 raises `mode` by one in the cycle after the sample.
- R4: An accepted sample with code above 213 and `mode` above 0 lowers `mode` by one in the cycle after the sample.
- R5: An accepted low sample at mode 7, or an accepted high sample at mode 0, pulses `out_of_range` for one cycle and leaves `mode` unchanged.
- R6: After each mode change, the next `settle_len` strobed samples are discarded. They change no mode and raise neither `amp_valid` nor `out_of_range`.
- R7: An accepted sample with code from 43 to 213 inclusive pulses `amp_valid` one cycle later. `amp_cmv` then equals 9000 + (128 − code)·52 + 100·off(mode) in units of 0.01 mV, where off(0)=0 and off(m)=60+50·(m−1) mV.
- R8: A cycle with `sample_valid` low changes nothing: `mode` holds, and `amp_valid` and `out_of_range` stay low in the next cycle.
- R9: `amp_valid`, `out_of_range` and a change of `mode` never occur in the same cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Strobe marking a new detector sample |
| sample_code | input | 8 | Digitized detector output |
| settle_len | input | 4 | Number of samples discarded after a mode change |
| mode | output | 3 | Current bias mode |
| therm | output | 7 | Thermometer code for the bias network |
| amp_valid | output | 1 | One-cycle strobe for a new amplitude estimate |
| amp_cmv | output | 16 | Amplitude estimate in 0.01 mV units |
| out_of_range | output | 1 | One-cycle flag: out-of-window sample at a mode limit |

## Verification
The bench builds the block with its default parameters: 8-bit codes, thresholds at 43 and 213, a 3-bit mode and a 4-bit settle count. With these values, seven steps reach either mode limit, so both saturation cases and every thermometer pattern are exercised. The bench runs with settle lengths of 0, 2 and 15. This covers the case with no settling, a short discard window and the longest discard window. The amplitude is checked at both window edges and at mid-scale in every mode.

// File: rtl/det_autorange_pkg.sv
package det_autorange_pkg;

    localparam int CODE_W_D   = 8;
    localparam int MODE_W_D   = 3;
    localparam int SETTLE_W_D = 4;
    localparam int AMP_W_D    = 16;

    // Classification of one sample against the linear window
    typedef enum logic [1:0] {
        BAND_IN   = 2'd0,
        BAND_LOW  = 2'd1,
        BAND_HIGH = 2'd2
    } band_e;

    // Per-sample decision carried from the controller
    typedef struct packed {
        logic go_up;
        logic go_down;
        logic at_limit;
        logic measure;
        logic discard;
    } step_t;

endpackage

// File: rtl/dar_window.sv
module dar_window
    import det_autorange_pkg::*;
#(
    parameter int CODE_W = CODE_W_D,
    parameter int LO_THR = 43,
    parameter int HI_THR = 213
) (
    input  logic [CODE_W-1:0] code,
    output band_e             band
);
    localparam logic [CODE_W-1:0] LO_L = CODE_W'(LO_THR);
    localparam logic [CODE_W-1:0] HI_L = CODE_W'(HI_THR);

    always_comb begin
        if (code < LO_L)
            band = BAND_LOW;
        else if (code > HI_L)
            band = BAND_HIGH;
        else
            band = BAND_IN;
    end
endmodule

// File: rtl/dar_mode_ctrl.sv
module dar_mode_ctrl
    import det_autorange_pkg::*;
#(
    parameter int MODE_W   = MODE_W_D,
    parameter int SETTLE_W = SETTLE_W_D
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_valid,
    input  band_e               band,
    input  logic [SETTLE_W-1:0] settle_len,
    output logic [MODE_W-1:0]   mode_q,
    output logic                oor_q,
    output logic                measure
);
    localparam logic [MODE_W-1:0] MODE_MAX = {MODE_W{1'b1}};

    logic [SETTLE_W-1:0] settle_q;
    step_t               step;

    // Decide what the current sample does
    always_comb begin
        step = '0;
        if (sample_valid) begin
            if (settle_q != '0) begin
                step.discard = 1'b1;
            end else begin
                unique case (band)
                    BAND_LOW: begin
                        if (mode_q == MODE_MAX) step.at_limit = 1'b1;
                        else                    step.go_up    = 1'b1;
                    end
                    BAND_HIGH: begin
                        if (mode_q == '0) step.at_limit = 1'b1;
                        else              step.go_down  = 1'b1;
                    end
                    default: step.measure = 1'b1;
                endcase
            end
        end
    end

    assign measure = step.measure;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            settle_q <= '0;
            oor_q    <= 1'b0;
        end else begin
            oor_q <= step.at_limit;
            if (step.discard)
                settle_q <= settle_q - 1'b1;
            if (step.go_up) begin
                mode_q   <= mode_q + 1'b1;
                settle_q <= settle_len;
            end else if (step.go_down) begin
                mode_q   <= mode_q - 1'b1;
                settle_q <= settle_len;
            end
        end
    end
endmodule

// File: rtl/dar_therm.sv
module dar_therm #(
    parameter int MODE_W = 3
) (
    input  logic [MODE_W-1:0]        mode,
    output logic [(1<<MODE_W)-2:0]   therm
);
    localparam int LINES = (1 << MODE_W) - 1;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign therm[i] = (mode > MODE_W'(i));
    end
endmodule

// File: rtl/dar_amp_est.sv
module dar_amp_est
    import det_autorange_pkg::*;
#(
    parameter int CODE_W     = CODE_W_D,
    parameter int MODE_W     = MODE_W_D,
    parameter int AMP_W      = AMP_W_D,
    parameter int MID_CODE   = 128,
    parameter int BASE_CMV   = 9000,
    parameter int SLOPE_CMV  = 52,
    parameter int FIRST_CMV  = 6000,
    parameter int STEP_CMV   = 5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              measure,
    input  logic [CODE_W-1:0] code,
    input  logic [MODE_W-1:0] mode,
    output logic              amp_valid,
    output logic [AMP_W-1:0]  amp_cmv
);
    localparam int EW    = AMP_W + 2;
    localparam int MODES = 1 << MODE_W;

    logic signed [EW-1:0] diff;
    logic signed [EW-1:0] slope_term;
    logic signed [EW-1:0] offset;
    logic signed [EW-1:0] total;

    always_comb begin
        diff       = EW'($signed({2'b00, CODE_W'(MID_CODE)}))
                   - EW'($signed({2'b00, code}));
        slope_term = diff * $signed(EW'(SLOPE_CMV));
        offset     = '0;
        for (int i = 1; i < MODES; i++) begin
            if (mode >= MODE_W'(i))
                offset = offset + ((i == 1) ? $signed(EW'(FIRST_CMV))
                                            : $signed(EW'(STEP_CMV)));
        end
        total = $signed(EW'(BASE_CMV)) + slope_term + offset;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            amp_valid <= 1'b0;
            amp_cmv   <= '0;
        end else begin
            amp_valid <= measure;
            if (measure)
                amp_cmv <= total[AMP_W-1:0];
        end
    end
endmodule

// File: rtl/det_autorange.sv
module det_autorange
    import det_autorange_pkg::*;
#(
    parameter int CODE_W   = CODE_W_D,
    parameter int MODE_W   = MODE_W_D,
    parameter int SETTLE_W = SETTLE_W_D,
    parameter int AMP_W    = AMP_W_D,
    parameter int LO_THR   = 43,
    parameter int HI_THR   = 213
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        sample_valid,
    input  logic [CODE_W-1:0]           sample_code,
    input  logic [SETTLE_W-1:0]         settle_len,
    output logic [MODE_W-1:0]           mode,
    output logic [(1<<MODE_W)-2:0]      therm,
    output logic                        amp_valid,
    output logic [AMP_W-1:0]            amp_cmv,
    output logic                        out_of_range
);
    band_e band;
    logic  measure;

    dar_window #(
        .CODE_W (CODE_W),
        .LO_THR (LO_THR),
        .HI_THR (HI_THR)
    ) u_window (
        .code (sample_code),
        .band (band)
    );

    dar_mode_ctrl #(
        .MODE_W   (MODE_W),
        .SETTLE_W (SETTLE_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .band         (band),
        .settle_len   (settle_len),
        .mode_q       (mode),
        .oor_q        (out_of_range),
        .measure      (measure)
    );

    dar_therm #(
        .MODE_W (MODE_W)
    ) u_therm (
        .mode  (mode),
        .therm (therm)
    );

    dar_amp_est #(
        .CODE_W (CODE_W),
        .MODE_W (MODE_W),
        .AMP_W  (AMP_W)
    ) u_amp (
        .clk       (clk),
        .rst       (rst),
        .measure   (measure),
        .code      (sample_code),
        .mode      (mode),
        .amp_valid (amp_valid),
        .amp_cmv   (amp_cmv)
    );
endmodule

// File: rtl/det_autorange_chk.sv
module det_autorange_chk #(
    parameter int MODE_W = 3,
    parameter int AMP_W  = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   sample_valid,
    input logic [MODE_W-1:0]      mode,
    input logic [(1<<MODE_W)-2:0] therm,
    input logic                   amp_valid,
    input logic [AMP_W-1:0]       amp_cmv,
    input logic                   out_of_range
);
    localparam int NT     = (1 << MODE_W) - 1;
    localparam int AMP_LO = 9000 - (213 - 128) * 52;
    localparam int AMP_HI = 9000 + (128 - 43) * 52 + 6000 + (NT - 1) * 5000;

    AST_THERM_COUNT: assert property (@(posedge clk) disable iff (rst)
        $countones(therm) == int'(mode));                               // R2
    AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (rst)
        ((therm + NT'(1)) & therm) == '0);                              // R2
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (mode != $past(mode)) |->
            (((MODE_W+1)'(mode) == (MODE_W+1)'($past(mode)) + 1'b1) ||
             ((MODE_W+1)'(mode) + 1'b1 == (MODE_W+1)'($past(mode))))); // R3
    AST_LIMIT_FLAG: assert property (@(posedge clk) disable iff (rst)
        out_of_range |-> (mode == '0 || mode == {MODE_W{1'b1}}));       // R5
    AST_AMP_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        amp_valid |-> (int'(amp_cmv) >= AMP_LO && int'(amp_cmv) <= AMP_HI)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> ($stable(mode) && !amp_valid && !out_of_range)); // R8
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({amp_valid, out_of_range, mode != $past(mode)}));      // R9
endmodule

bind det_autorange det_autorange_chk #(
    .MODE_W (MODE_W),
    .AMP_W  (AMP_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .mode         (mode),
    .therm        (therm),
    .amp_valid    (amp_valid),
    .amp_cmv      (amp_cmv),
    .out_of_range (out_of_range)
);

// File: tb/det_autorange_bench.sv
module det_autorange_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_valid = 1'b0;
    logic [7:0] sample_code = 8'd0;
    logic [3:0] settle_len = 4'd0;
    logic [2:0] mode;
    logic [6:0] therm;
    logic       amp_valid;
    logic [15:0] amp_cmv;
    logic       out_of_range;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    det_autorange u_det_autorange (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .sample_code  (sample_code),
        .settle_len   (settle_len),
        .mode         (mode),
        .therm        (therm),
        .amp_valid    (amp_valid),
        .amp_cmv      (amp_cmv),
        .out_of_range (out_of_range)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_amp(input int code, input int m);
        int off_mv;
        off_mv = (m == 0) ? 0 : 60 + 50 * (m - 1);
        return 9000 + (128 - code) * 52 + 100 * off_mv;
    endfunction

    function automatic int exp_therm(input int m);
        return (1 << m) - 1;
    endfunction

    // Present one strobed sample; outputs are then sampled at the next negedge
    task automatic send(input int code);
        @(negedge clk);
        sample_valid = 1'b1;
        sample_code  = 8'(code);
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic pulses_drop(input string req);
        @(negedge clk);
        check({req, " amp_valid drops"}, int'(amp_valid), 0);
        check({req, " out_of_range drops"}, int'(out_of_range), 0);
    endtask

    task automatic t_reset;
        check("R1 mode", int'(mode), 0);
        check("R1 therm", int'(therm), 0);
        check("R1 amp_valid", int'(amp_valid), 0);
        check("R1 out_of_range", int'(out_of_range), 0);
    endtask

    task automatic t_window_edges;
        settle_len = 4'd0;
        send(128);
        check("R7 amp at mid", int'(amp_cmv), exp_amp(128, 0));
        check("R7 amp_valid", int'(amp_valid), 1);
        check("R9 no flag with amp", int'(out_of_range), 0);
        pulses_drop("R9");
        send(43);
        check("R7 low edge amp_valid", int'(amp_valid), 1);
        check("R7 low edge amp", int'(amp_cmv), exp_amp(43, 0));
        check("R7 low edge mode", int'(mode), 0);
        send(213);
        check("R7 high edge amp_valid", int'(amp_valid), 1);
        check("R7 high edge amp", int'(amp_cmv), exp_amp(213, 0));
    endtask

    task automatic t_idle;
        @(negedge clk);
        sample_code = 8'd5;
        repeat (4) begin
            @(negedge clk);
            check("R8 mode holds", int'(mode), 0);
            check("R8 no amp_valid", int'(amp_valid), 0);
            check("R8 no flag", int'(out_of_range), 0);
        end
    endtask

    task automatic t_climb;
        settle_len = 4'd0;
        for (int m = 1; m <= 7; m++) begin
            send((m % 2 == 0) ? 0 : 42);
            check("R3 mode up", int'(mode), m);
            check("R2 therm", int'(therm), exp_therm(m));
            check("R9 no amp on step", int'(amp_valid), 0);
            send(128);
            check("R7 amp per mode", int'(amp_cmv), exp_amp(128, m));
        end
        send(42);
        check("R5 top flag", int'(out_of_range), 1);
        check("R5 top mode held", int'(mode), 7);
        pulses_drop("R5");
        send(100);
        check("R7 amp mode 7", int'(amp_cmv), exp_amp(100, 7));
    endtask

    task automatic t_descend;
        settle_len = 4'd0;
        for (int m = 6; m >= 0; m--) begin
            send((m % 2 == 0) ? 214 : 255);
            check("R4 mode down", int'(mode), m);
            check("R2 therm", int'(therm), exp_therm(m));
            check("R9 no flag on step", int'(out_of_range), 0);
        end
        send(250);
        check("R5 bottom flag", int'(out_of_range), 1);
        check("R5 bottom mode held", int'(mode), 0);
        check("R9 no amp with flag", int'(amp_valid), 0);
    endtask

    task automatic t_settle(input int n);
        settle_len = 4'(n);
        send(10);
        check("R6 step before settle", int'(mode), 1);
        for (int k = 0; k < n; k++) begin
            send((k % 2 == 0) ? 0 : 128);
            check("R6 discarded mode", int'(mode), 1);
            check("R6 discarded amp", int'(amp_valid), 0);
            check("R6 discarded flag", int'(out_of_range), 0);
        end
        send(128);
        check("R6 accepted after settle", int'(amp_valid), 1);
        check("R6 amp after settle", int'(amp_cmv), exp_amp(128, 1));
        send(240);
        check("R6 return to mode 0", int'(mode), 0);
        for (int k = 0; k < n; k++) send(240);
        check("R6 no flag while settling", int'(out_of_range), 0);
        send(240);
        check("R5 flag after settle", int'(out_of_range), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_window_edges();
        t_idle();
        t_climb();
        t_descend();
        t_settle(2);
        t_settle(15);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule